// File: doc/BRIEF.md
# Five-Decade Multi-Mode Decimal Counter

This block is a chain of five decimal digits (units, tens, hundreds, thousands, ten-thousands) that advances once on every rising edge of its clock. A two-bit mode input sets how the lowest digit behaves and when it passes a carry to the tens digit. The lowest digit can be an ordinary units digit, a hidden divide-by-ten prescaler with round-off, or a half-unit digit that shows only 0 or 5. A test setting drives several digits straight from the clock, so the upper decades can be exercised in a few hundred cycles instead of a hundred thousand.

The design is fully synchronous. Carries are formed as clock enables from the terminal state of each lower digit, so no stage is clocked by another stage's output. A one-cycle carry-out pulse marks each wrap of the top decade, for cascading a further counter. A flag shows whether the lowest digit is currently blanked.

Top module: `dec5_counter`

## Requirements
- R1: While rst_ni is low, every digit reads 0 and carry_o is high. Reset takes effect at once, without waiting for a clock edge, and counting resumes on the first rising edge after release.
- R2: With {mode_a_i, mode_b_i} = 00, the count_o field at bits [3:0] shows the units digit. The units digit steps by one on every edge and wraps from 9 to 0. The tens digit steps on the edge where units wrap.
- R3: The hundreds, thousands and ten-thousands digits each step on the edge where the digit below them wraps from 9 to 0. Digit k occupies count_o bits [4k+3:4k], with units at k=0.
- R4: With {mode_a_i, mode_b_i} = 01 (test), the units field reads 0. Tens and thousands step on every edge. Hundreds step when tens wrap, and ten-thousands step when thousands wrap.
- R5: With {mode_a_i, mode_b_i} = 11 (round-off), the units field reads 0. The first stage keeps counting 0 to 9 internally, and tens step on the edge where it moves from 4 to 5.
- R6: With {mode_a_i, mode_b_i} = 10 (half-unit), the units field reads 5 while the internal first stage is 3 to 7, and reads 0 otherwise. Tens step on the edge where the first stage moves from 7 to 8.
- R7: carry_o goes high for exactly one clock period following the edge on which the ten-thousands digit wraps from 9 to 0.
- R8: inhib_o is high exactly when mode_b_i is high, that is in modes 01 and 11.
- R9: A change of mode alters the units field at once and alters carry timing from the next edge. The internal first-stage count is kept across mode changes.
- R10: Every digit always holds a value from 0 to 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Count clock; every rising edge is one count |
| rst_ni | input | 1 | Asynchronous active-low master clear |
| mode_a_i | input | 1 | Mode select, upper bit |
| mode_b_i | input | 1 | Mode select, lower bit |
| count_o | output | 20 | Five BCD digits, units in bits [3:0] |
| carry_o | output | 1 | One-period pulse on top-decade wrap; high during reset |
| inhib_o | output | 1 | High when the units field is blanked |

## Verification
In plain mode a long run crosses every decade boundary and the full 99999-to-0 wrap. This separates correct chaining from off-by-one terminal detection and shows that the carry pulse lasts a single period. Test mode is run to 99 and 100 edges, which shows that tens and thousands take the clock directly while hundreds and ten-thousands still take carries. Round-off and half-unit modes are sampled on both sides of the 4-to-5 and 7-to-8 transitions, together with the 0/5 display bands, so a wrong carry point or band edge gives a different tens value. A mid-count mode switch, and a switch back, show that the hidden first-stage count survives and that the new carry point applies on the very next edge.

// File: rtl/dec5_pkg.sv
`timescale 1ns/1ps
package dec5_pkg;
  localparam int DIG_W = 4;
  localparam logic [DIG_W-1:0] DIG_TOP = 4'd9;

  // encoding is {mode_a, mode_b}
  typedef enum logic [1:0] {
    MODE_PLAIN = 2'b00,
    MODE_TEST  = 2'b01,
    MODE_HALF  = 2'b10,
    MODE_ROUND = 2'b11
  } mode_e;
endpackage

// File: rtl/dec5_cell.sv
`timescale 1ns/1ps
module dec5_cell #(
  parameter int              W   = 4,
  parameter logic [W-1:0]    TOP = 4'd9
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  output logic [W-1:0] val_o,
  output logic         last_o
);
  logic [W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q <= '0;
    else if (en_i) q <= (q == TOP) ? '0 : q + 1'b1;
  end

  assign val_o  = q;
  assign last_o = (q == TOP);

  // R10
  a_r10_digit_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    val_o <= TOP);
  // R3: a stage without enable holds
  a_r3_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(val_o));
endmodule

// File: rtl/dec5_lead.sv
`timescale 1ns/1ps
module dec5_lead
  import dec5_pkg::*;
(
  input  mode_e            mode_i,
  input  logic [DIG_W-1:0] cnt_i,
  output logic [DIG_W-1:0] shown_o,
  output logic             hit_o
);
  always_comb begin
    shown_o = '0;
    hit_o   = 1'b0;
    unique case (mode_i)
      MODE_PLAIN: begin
        shown_o = cnt_i;
        hit_o   = (cnt_i == DIG_TOP);
      end
      MODE_TEST: begin
        shown_o = '0;
        hit_o   = 1'b0;
      end
      MODE_HALF: begin
        shown_o = (cnt_i >= 4'd3 && cnt_i <= 4'd7) ? 4'd5 : 4'd0;
        hit_o   = (cnt_i == 4'd7);
      end
      MODE_ROUND: begin
        shown_o = '0;
        hit_o   = (cnt_i == 4'd4);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/dec5_counter.sv
`timescale 1ns/1ps
module dec5_counter
  import dec5_pkg::*;
#(
  parameter int                   NUM_DIGITS = 5,
  // stages clocked directly in test mode
  parameter logic [NUM_DIGITS-1:0] TEST_MASK = 5'b01011
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          mode_a_i,
  input  logic                          mode_b_i,
  output logic [NUM_DIGITS*DIG_W-1:0]   count_o,
  output logic                          carry_o,
  output logic                          inhib_o
);
  localparam int TOP_IDX = NUM_DIGITS - 1;

  mode_e                              mode;
  logic [NUM_DIGITS-1:0][DIG_W-1:0]   cnt;
  logic [NUM_DIGITS-1:0]              en;
  logic [NUM_DIGITS-1:0]              last;
  logic [DIG_W-1:0]                   lead_shown;
  logic                               lead_hit;
  logic                               carry_q;

  assign mode = mode_e'({mode_a_i, mode_b_i});

  dec5_lead u_lead (
    .mode_i  (mode),
    .cnt_i   (cnt[0]),
    .shown_o (lead_shown),
    .hit_o   (lead_hit)
  );

  assign en[0] = 1'b1;

  for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_stage
    if (g == 1) begin : g_second
      assign en[g] = ((mode == MODE_TEST) && TEST_MASK[g]) | lead_hit;
    end else if (g > 1) begin : g_upper
      assign en[g] = ((mode == MODE_TEST) && TEST_MASK[g]) | (en[g-1] & last[g-1]);
    end

    dec5_cell #(.W(DIG_W), .TOP(DIG_TOP)) u_cell (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (en[g]),
      .val_o  (cnt[g]),
      .last_o (last[g])
    );

    if (g == 0) begin : g_out_lead
      assign count_o[g*DIG_W +: DIG_W] = lead_shown;
    end else begin : g_out_dig
      assign count_o[g*DIG_W +: DIG_W] = cnt[g];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) carry_q <= 1'b0;
    else         carry_q <= en[TOP_IDX] & last[TOP_IDX];
  end

  assign carry_o = carry_q | ~rst_ni;
  assign inhib_o = mode_b_i;

  // R7
  a_r7_carry_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    carry_q |=> !carry_q);
  a_r7_carry_top_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    carry_q |-> (count_o[TOP_IDX*DIG_W +: DIG_W] == '0));
  // R4 / R5: blanked first stage
  a_r5_lead_blank: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_b_i |-> (count_o[DIG_W-1:0] == '0));
  // R6
  a_r6_half_values: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_HALF) |-> (count_o[DIG_W-1:0] == 4'd0 || count_o[DIG_W-1:0] == 4'd5));
  // R8
  a_r8_inhib_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inhib_o == (mode == MODE_TEST || mode == MODE_ROUND));
endmodule

// File: tb/sim_dec5_counter.sv
`timescale 1ns/1ps
module sim_dec5_counter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ma = 1'b0;
  logic        mb = 1'b0;
  logic [19:0] cnt;
  logic        cout;
  logic        inh;
  int          n_chk = 0;
  int          n_err = 0;

  always #5 clk = ~clk;

  dec5_counter u0 (
    .clk_i(clk), .rst_ni(rst_n), .mode_a_i(ma), .mode_b_i(mb),
    .count_o(cnt), .carry_o(cout), .inhib_o(inh)
  );

  function automatic logic [19:0] dv(int d4, int d3, int d2, int d1, int d0);
    return {4'(d4), 4'(d3), 4'(d2), 4'(d1), 4'(d0)};
  endfunction

  task automatic chk(string req, logic [19:0] exp_cnt, logic exp_c, logic exp_i);
    n_chk++;
    if (cnt !== exp_cnt || cout !== exp_c || inh !== exp_i) begin
      n_err++;
      $display("FAIL %s: got cnt=%h carry=%b inhib=%b, expected cnt=%h carry=%b inhib=%b",
               req, cnt, cout, inh, exp_cnt, exp_c, exp_i);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset(logic a, logic b);
    @(negedge clk);
    ma = a; mb = b;
    rst_n = 1'b0;
    #2;
    chk("R1 reset state", dv(0,0,0,0,0), 1'b1, b);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 after release", dv(0,0,0,0,0), 1'b0, b);
  endtask

  task automatic t_plain();
    do_reset(1'b0, 1'b0);
    tick(9);      chk("R2 units at 9", dv(0,0,0,0,9), 1'b0, 1'b0);
    tick(1);      chk("R2 units wrap into tens", dv(0,0,0,1,0), 1'b0, 1'b0);
    tick(89);     chk("R3 count 99", dv(0,0,0,9,9), 1'b0, 1'b0);
    tick(1);      chk("R3 hundreds step", dv(0,0,1,0,0), 1'b0, 1'b0);
    tick(9899);   chk("R3 count 9999", dv(0,9,9,9,9), 1'b0, 1'b0);
    tick(1);      chk("R3 ten-thousands step", dv(1,0,0,0,0), 1'b0, 1'b0);
    tick(89999);  chk("R7 count 99999 no carry", dv(9,9,9,9,9), 1'b0, 1'b0);
    tick(1);      chk("R7 wrap carry high", dv(0,0,0,0,0), 1'b1, 1'b0);
    tick(1);      chk("R7 carry one period", dv(0,0,0,0,1), 1'b0, 1'b0);
    // R1: asynchronous clear mid-count
    #2 rst_n = 1'b0;
    #1 chk("R1 async clear mid-count", dv(0,0,0,0,0), 1'b1, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_test_mode();
    do_reset(1'b0, 1'b1);
    tick(37);  chk("R4 test mode n=37", dv(3,7,3,7,0), 1'b0, 1'b1);
    tick(62);  chk("R4 test mode n=99", dv(9,9,9,9,0), 1'b0, 1'b1);
    tick(1);   chk("R7 test mode top wrap", dv(0,0,0,0,0), 1'b1, 1'b1);
    tick(1);   chk("R7 test mode carry drops", dv(0,1,0,1,0), 1'b0, 1'b1);
  endtask

  task automatic t_round();
    do_reset(1'b1, 1'b1);
    tick(4);   chk("R5 before 4->5", dv(0,0,0,0,0), 1'b0, 1'b1);
    tick(1);   chk("R5 carry on 4->5", dv(0,0,0,1,0), 1'b0, 1'b1);
    tick(9);   chk("R5 n=14", dv(0,0,0,1,0), 1'b0, 1'b1);
    tick(1);   chk("R5 n=15", dv(0,0,0,2,0), 1'b0, 1'b1);
    tick(100); chk("R5 n=115", dv(0,0,1,2,0), 1'b0, 1'b1);
  endtask

  task automatic t_half();
    do_reset(1'b1, 1'b0);
    tick(2);   chk("R6 n=2 shows 0", dv(0,0,0,0,0), 1'b0, 1'b0);
    tick(1);   chk("R6 n=3 shows 5", dv(0,0,0,0,5), 1'b0, 1'b0);
    tick(4);   chk("R6 n=7 shows 5", dv(0,0,0,0,5), 1'b0, 1'b0);
    tick(1);   chk("R6 n=8 carry 7->8", dv(0,0,0,1,0), 1'b0, 1'b0);
    tick(2);   chk("R6 n=10 shows 0", dv(0,0,0,1,0), 1'b0, 1'b0);
    tick(3);   chk("R6 n=13 shows 5", dv(0,0,0,1,5), 1'b0, 1'b0);
    tick(5);   chk("R6 n=18 second carry", dv(0,0,0,2,0), 1'b0, 1'b0);
  endtask

  task automatic t_switch();
    do_reset(1'b0, 1'b0);
    tick(23);  chk("R9 plain count 23", dv(0,0,0,2,3), 1'b0, 1'b0);
    ma = 1'b1; mb = 1'b1;
    #1 chk("R9 R8 switch to round blanks units", dv(0,0,0,2,0), 1'b0, 1'b1);
    tick(1);   chk("R9 internal 4 no carry", dv(0,0,0,2,0), 1'b0, 1'b1);
    tick(1);   chk("R9 round carry next edge", dv(0,0,0,3,0), 1'b0, 1'b1);
    ma = 1'b0; mb = 1'b0;
    #1 chk("R9 R8 internal count kept", dv(0,0,0,3,5), 1'b0, 1'b0);
    ma = 1'b1;
    #1 chk("R8 half mode flag low", dv(0,0,0,3,5), 1'b0, 1'b0);
  endtask

  initial begin
    #1900000;
    n_chk++;
    n_err++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    t_plain();
    t_test_mode();
    t_round();
    t_half();
    t_switch();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule